// File: doc/BRIEF.md
# Clause 45 MDIO Management Controller

This block is a small register-driven engine for indirect Clause 45 management accesses to 10GbE-class PHYs. Software first loads a 16-bit target register number into the address register. It then writes the management register with the port address, the device address, a 3-bit command and, for a write, the 16-bit data value. That single write launches a two-frame sequence on the serial management bus. An address frame carries the stored register number. A write frame or a read frame then follows, sent to the same port and device.

The controller shows busy in the management register from the launch until the second frame has ended. On a read it releases the data line for the turnaround and the data field and samples the PHY's reply. When the PHY pulled the line low in the second turnaround bit, the controller stores the 16 returned bits and raises read-valid. The management clock is produced only while an access is in progress. Its half period is a parameter, so a full access takes a fixed number of clock cycles. That number can be sized to fit well inside a software polling budget of about one millisecond.

Top module: `c45_mdio_ctrl`

## Requirements
- R1: After reset both registers read zero, busy (bit 30) is low, `mdc` is low and `mdio_oe` is low; whenever busy is low, `mdc` and `mdio_oe` stay low.
- R2: The address register sits at byte offset 0x8, stores write-data bits 15:0 and reads back zero in bits 31:16; the management register sits at offset 0x0 and reads back data in 15:0, port in 20:16, device in 25:21, command in 28:26, read-valid in 29, busy in 30 and zero in 31.
- R3: A write to offset 0x0 while idle with command 5 (write) or 7 (read) sets busy from the next cycle; busy then stays high for exactly 128 management-clock periods (256 x `MDC_HALF` cycles) and falls.
- R4: The first frame is an address frame, driven MSB first: 32 ones, start 00, opcode 00, the 5-bit port, the 5-bit device, turnaround 10, then the 16 bits of the address register.
- R5: For command 5 the second frame is 32 ones, 00, opcode 01, port, device, 10 and management data bits 15:0, MSB first; after it the data field still holds that value.
- R6: For command 7 the second frame is 32 ones, 00, opcode 11, port and device, after which `mdio_oe` is low for its last 18 bit times (turnaround and data).
- R7: Each bit lasts 2 x `MDC_HALF` cycles: `mdc` is low for the first `MDC_HALF` cycles and high for the rest; `mdio_o` and `mdio_oe` change only at the start of a bit, never while `mdc` is high.
- R8: Read-valid is cleared at launch. After a read in which `mdio_i` is 0 at the end of the second turnaround bit, read-valid is 1 and bits 15:0 hold the 16 following bits, MSB first, each sampled in the last cycle of its `mdc` high phase.
- R9: If `mdio_i` is 1 in the second turnaround bit, read-valid stays 0 and bits 15:0 keep the data value written at launch.
- R10: A management write whose command is neither 5 nor 7 starts nothing, leaves busy low and leaves the management register unchanged.
- R11: Writes to either register while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Byte offset of the register being written or read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register selected by `reg_addr` (combinational) |
| mdc | output | 1 | Management clock, active only during an access |
| mdio_o | output | 1 | Management data driven by the controller |
| mdio_oe | output | 1 | High while the controller drives the data line |
| mdio_i | input | 1 | Management data line as seen at the pin |

## Verification
The sequence runs with several port, device and register-address patterns: all-zero, all-ones and mixed values. Every bit field therefore has to sit in its own frame position, and a swapped or shifted field shows up as a line mismatch at a known bit time. Reads are run once with a good turnaround and once with a missing one, which separates the valid-update path from the keep-old-data path. Illegal command codes, and writes issued while an access is in flight, are checked by reading the registers back and watching that busy, the clock and the line stay quiet.

// File: rtl/c45_mdio_pkg.sv
// Package: shared constants and the frame builder for the Clause 45
// management controller. Assumes 64-bit frames: 32 preamble, 2 start,
// 2 opcode, 5 port, 5 device, 2 turnaround, 16 data.
package c45_mdio_pkg;

    localparam int FRAME_BITS = 64;
    localparam int TA_BIT     = 46;
    localparam int TA_LAST    = 47;
    localparam int LAST_BIT   = FRAME_BITS - 1;
    localparam int REG_W      = 32;

    localparam logic [1:0] OPC_ADDR  = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b11;

    localparam logic [2:0] CMD_WR = 3'd5;
    localparam logic [2:0] CMD_RD = 3'd7;

    localparam int MGMT_OFS = 0;
    localparam int ADDR_OFS = 8;

    typedef logic [FRAME_BITS-1:0] frame_t;

    // Build a complete frame, MSB is sent first.
    function automatic frame_t build_frame(input logic [1:0]  opc,
                                           input logic [4:0]  prt,
                                           input logic [4:0]  dev,
                                           input logic [15:0] payload);
        return {32'hFFFF_FFFF, 2'b00, opc, prt, dev, 2'b10, payload};
    endfunction

endpackage

// File: rtl/c45_mdc_gen.sv
// Management clock generator. Runs only while 'run' is high and restarts
// its phase at zero each time an access begins. Assumes HALF >= 1.
// mdc is low for the first HALF cycles of a bit and high for the rest;
// bit_end marks the last cycle of each bit.
module c45_mdc_gen #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic bit_end
);
    localparam int PER = 2 * HALF;
    localparam int PW  = (PER > 2) ? $clog2(PER) : 1;

    logic [PW-1:0] phase_q;

    // Phase counter within one bit time, held at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase_q <= '0;
        end else if (phase_q == PW'(PER - 1)) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign mdc     = run && (phase_q >= PW'(HALF));
    assign bit_end = run && (phase_q == PW'(PER - 1));

endmodule

// File: rtl/c45_frame_seq.sv
// Two-frame sequencer. On 'start' it loads an address frame and queues the
// write or read frame, then shifts one bit per bit_end. During the read
// frame it releases the line from the turnaround on, checks the second
// turnaround bit and collects 16 data bits. 'done' pulses in the cycle
// the last bit ends; rd_data is valid in that cycle.
module c45_frame_seq
    import c45_mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        is_read,
    input  logic [4:0]  prt,
    input  logic [4:0]  dev,
    input  logic [15:0] addr16,
    input  logic [15:0] wdata16,
    input  logic        bit_end,
    input  logic        mdio_i,
    output logic        run,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        done,
    output logic        rd_ok,
    output logic [15:0] rd_data
);
    localparam int BW = $clog2(FRAME_BITS);

    logic          run_q;
    logic          second_q;
    logic          rd_q;
    logic [BW-1:0] bit_q;
    frame_t        sh_q;
    frame_t        next_q;
    logic          ta_ok_q;
    logic [15:0]   cap_q;
    logic          last_bit;
    logic          listen;

    assign last_bit = bit_end && (bit_q == BW'(LAST_BIT));
    assign listen   = second_q && rd_q;

    // Access state: running flag, frame index and bit index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            second_q <= 1'b0;
            rd_q     <= 1'b0;
            bit_q    <= '0;
        end else if (start && !run_q) begin
            run_q    <= 1'b1;
            second_q <= 1'b0;
            rd_q     <= is_read;
            bit_q    <= '0;
        end else if (run_q && bit_end) begin
            if (last_bit) begin
                bit_q <= '0;
                if (second_q) begin
                    run_q    <= 1'b0;
                    second_q <= 1'b0;
                end else begin
                    second_q <= 1'b1;
                end
            end else begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    // Outgoing shift register and the frame queued behind it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            next_q <= '0;
        end else if (start && !run_q) begin
            sh_q   <= build_frame(OPC_ADDR, prt, dev, addr16);
            next_q <= build_frame(is_read ? OPC_READ : OPC_WRITE, prt, dev,
                                  is_read ? 16'hFFFF : wdata16);
        end else if (run_q && bit_end) begin
            if (last_bit && !second_q) begin
                sh_q <= next_q;
            end else begin
                sh_q <= {sh_q[FRAME_BITS-2:0], 1'b1};
            end
        end
    end

    // Read capture: turnaround check and incoming data bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ta_ok_q <= 1'b0;
            cap_q   <= '0;
        end else if (start && !run_q) begin
            ta_ok_q <= 1'b0;
        end else if (run_q && bit_end && listen) begin
            if (bit_q == BW'(TA_LAST)) begin
                ta_ok_q <= !mdio_i;
            end
            if (bit_q > BW'(TA_LAST)) begin
                cap_q <= {cap_q[14:0], mdio_i};
            end
        end
    end

    assign run     = run_q;
    assign mdio_o  = sh_q[FRAME_BITS-1];
    assign mdio_oe = run_q && !(listen && (bit_q >= BW'(TA_BIT)));
    assign done    = run_q && second_q && last_bit;
    assign rd_ok   = ta_ok_q;
    assign rd_data = {cap_q[14:0], mdio_i};

endmodule

// File: rtl/c45_mdio_regs.sv
// Register file: the address register and the management register.
// Decodes launches, blocks all writes while busy and takes read results
// when the sequencer finishes. Read data is combinational on reg_addr.
module c45_mdio_regs
    import c45_mdio_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              busy,
    input  logic              done,
    input  logic              rd_ok,
    input  logic [15:0]       rd_data,
    output logic [REG_W-1:0]  rdata,
    output logic              start,
    output logic              is_read,
    output logic [4:0]        prt,
    output logic [4:0]        dev,
    output logic [15:0]       addr16,
    output logic [15:0]       wdata16,
    output logic              rd_valid
);
    logic [15:0] addr_q;
    logic [15:0] data_q;
    logic [4:0]  prt_q;
    logic [4:0]  dev_q;
    logic [2:0]  cmd_q;
    logic        valid_q;
    logic        mgmt_hit;
    logic        addr_hit;
    logic        cmd_ok;
    logic [2:0]  cmd_in;
    logic        unused_hi;

    assign cmd_in    = wdata[28:26];
    assign cmd_ok    = (cmd_in == CMD_WR) || (cmd_in == CMD_RD);
    assign mgmt_hit  = we && !busy && (addr == ADDR_W'(MGMT_OFS));
    assign addr_hit  = we && !busy && (addr == ADDR_W'(ADDR_OFS));
    assign start     = mgmt_hit && cmd_ok;
    assign unused_hi = ^wdata[31:29];

    // Address register, loaded only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (addr_hit) begin
            addr_q <= wdata[15:0];
        end
    end

    // Management fields: latched on launch, data replaced by a good read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            prt_q   <= '0;
            dev_q   <= '0;
            cmd_q   <= '0;
            valid_q <= 1'b0;
        end else if (start) begin
            data_q  <= wdata[15:0];
            prt_q   <= wdata[20:16];
            dev_q   <= wdata[25:21];
            cmd_q   <= cmd_in;
            valid_q <= 1'b0;
        end else if (done && (cmd_q == CMD_RD) && rd_ok) begin
            data_q  <= rd_data;
            valid_q <= 1'b1;
        end
    end

    // Read-back multiplexer.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(MGMT_OFS)) begin
            rdata = {1'b0, busy, valid_q, cmd_q, dev_q, prt_q, data_q};
        end else if (addr == ADDR_W'(ADDR_OFS)) begin
            rdata = {16'h0000, addr_q};
        end
    end

    assign is_read  = (cmd_in == CMD_RD);
    assign prt      = wdata[20:16];
    assign dev      = wdata[25:21];
    assign wdata16  = wdata[15:0];
    assign addr16   = addr_q;
    assign rd_valid = valid_q;

endmodule

// File: rtl/c45_mdio_ctrl.sv
// Top of the Clause 45 management controller: register file, two-frame
// sequencer and management clock generator. The data line is split into
// mdio_o / mdio_oe / mdio_i; the pad and its pull-up sit outside.
module c45_mdio_ctrl
    import c45_mdio_pkg::*;
#(
    parameter int MDC_HALF = 2,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic        busy_w;
    logic        start_w;
    logic        is_read_w;
    logic [4:0]  prt_w;
    logic [4:0]  dev_w;
    logic [15:0] addr16_w;
    logic [15:0] wdata16_w;
    logic        bit_end_w;
    logic        done_w;
    logic        rd_ok_w;
    logic [15:0] rd_data_w;
    logic        rd_valid_w;

    c45_mdio_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .busy     (busy_w),
        .done     (done_w),
        .rd_ok    (rd_ok_w),
        .rd_data  (rd_data_w),
        .rdata    (reg_rdata),
        .start    (start_w),
        .is_read  (is_read_w),
        .prt      (prt_w),
        .dev      (dev_w),
        .addr16   (addr16_w),
        .wdata16  (wdata16_w),
        .rd_valid (rd_valid_w)
    );

    c45_frame_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_w),
        .is_read (is_read_w),
        .prt     (prt_w),
        .dev     (dev_w),
        .addr16  (addr16_w),
        .wdata16 (wdata16_w),
        .bit_end (bit_end_w),
        .mdio_i  (mdio_i),
        .run     (busy_w),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .done    (done_w),
        .rd_ok   (rd_ok_w),
        .rd_data (rd_data_w)
    );

    c45_mdc_gen #(.HALF(MDC_HALF)) u_mdc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy_w),
        .mdc     (mdc),
        .bit_end (bit_end_w)
    );

endmodule

// File: rtl/c45_mdio_checker.sv
// Protocol checker for the management controller, bound to the top.
// Counts busy cycles to check the access length without deep $past.
module c45_mdio_checker #(
    parameter int HALF   = 2,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [2:0]        cmd,
    input logic              busy,
    input logic              mdc,
    input logic              mdio_o,
    input logic              mdio_oe,
    input logic              rd_valid
);
    localparam int LEN = 256 * HALF;
    localparam int CW  = $clog2(LEN + 1) + 1;

    logic [CW-1:0] cnt_q;
    logic          launch_req;

    assign launch_req = reg_we && (reg_addr == '0) &&
                        ((cmd == 3'd5) || (cmd == 3'd7));

    // Length of the current busy window.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            cnt_q <= busy ? CW'(1) : '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    a_r3_launch_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(launch_req));

    a_r3_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (cnt_q == CW'(LEN)));

    a_r7_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    a_r8_valid_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !rd_valid);

    a_r10_bad_cmd_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && reg_we && (reg_addr == '0) && (cmd != 3'd5) && (cmd != 3'd7))
        |=> !busy);

endmodule

bind c45_mdio_ctrl c45_mdio_checker #(.HALF(MDC_HALF), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .cmd      (reg_wdata[28:26]),
    .busy     (busy_w),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rd_valid (rd_valid_w)
);

// File: tb/test_c45_mdio_ctrl.sv
// Bench: behavioural per-cycle model of line, clock and busy, plus a PHY
// responder and register read-back checks.
module test_c45_mdio_ctrl;
    localparam int HALF  = 2;
    localparam int P     = 2 * HALF;
    localparam int OPLEN = 2 * 64 * P;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = 32'h0;
    wire  [31:0] reg_rdata;
    wire         mdc, mdio_o, mdio_oe;
    logic        phy_en = 1'b0;
    logic        phy_v = 1'b1;
    wire         mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_v : 1'b1);

    int total = 0;
    int bad = 0;

    // model state
    bit          m_on = 0;
    int          m_j = 0;
    int          m_err = 0;
    string       m_tag = "";
    logic [63:0] m_f0, m_f1;
    bit          m_rd = 0;
    logic        m_ta = 1'b0;
    logic [15:0] m_resp = 16'h0;
    int          mf, mb, mph;
    logic        e_busy, e_mdc, e_oe, e_dat;

    c45_mdio_ctrl #(.MDC_HALF(HALF), .ADDR_W(4)) i_c45_mdio_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #5 clk = ~clk;

    function automatic logic [63:0] frame_bits(input logic [1:0] opc, input logic [4:0] p,
                                               input logic [4:0] d, input logic [15:0] pay);
        bit q[$];
        logic [63:0] v;
        repeat (32) q.push_back(1'b1);
        q.push_back(1'b0); q.push_back(1'b0);
        q.push_back(opc[1]); q.push_back(opc[0]);
        for (int i = 4; i >= 0; i--) q.push_back(p[i]);
        for (int i = 4; i >= 0; i--) q.push_back(d[i]);
        q.push_back(1'b1); q.push_back(1'b0);
        for (int i = 15; i >= 0; i--) q.push_back(pay[i]);
        for (int i = 0; i < 64; i++) v[63-i] = q[i];
        return v;
    endfunction

    function automatic logic [31:0] mk(input logic [2:0] c, input logic [4:0] p,
                                       input logic [4:0] d, input logic [15:0] dat);
        return (32'(c) << 26) | (32'(d) << 21) | (32'(p) << 16) | 32'(dat);
    endfunction

    task automatic note(input string s, input logic a, input logic e);
        if (m_err == 0)
            $display("FAIL %s cycle %0d %s act=%b exp=%b", m_tag, m_j, s, a, e);
        m_err++;
    endtask

    task automatic chk(input string r, input logic [31:0] a, input logic [31:0] e);
        total++;
        if (a !== e) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", r, a, e);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input bit launch);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        if (launch) begin
            m_j = 0;
            m_on = 1;
        end
        #1 reg_we = 1'b0; reg_addr = 4'h0;
    endtask

    // Per-cycle reference model and PHY responder.
    always @(negedge clk) begin
        if (m_on) begin
            if (m_j < OPLEN) begin
                mf = m_j / (64 * P); mb = (m_j / P) % 64; mph = m_j % P;
                e_busy = 1'b1;
                e_mdc = (mph >= HALF);
                e_oe = !(mf == 1 && m_rd && mb >= 46);
                e_dat = (mf == 1) ? m_f1[63-mb] : m_f0[63-mb];
                phy_en = (mf == 1 && m_rd && mb >= 47);
                phy_v = (mb >= 48) ? m_resp[63-mb] : m_ta;
            end else begin
                e_busy = 1'b0; e_mdc = 1'b0; e_oe = 1'b0; e_dat = 1'b0;
                phy_en = 1'b0;
            end
            if (reg_addr == 4'h0 && reg_rdata[30] !== e_busy) note("busy", reg_rdata[30], e_busy);
            if (mdc !== e_mdc) note("mdc", mdc, e_mdc);
            if (mdio_oe !== e_oe) note("mdio_oe", mdio_oe, e_oe);
            if (e_oe && mdio_o !== e_dat) note("mdio_o", mdio_o, e_dat);
            if (m_j >= OPLEN) m_on = 0;
            else m_j++;
        end
    end

    task automatic run_op(input logic [2:0] c, input logic [4:0] p, input logic [4:0] d,
                          input logic [15:0] dat, input logic [15:0] ra, input logic ta,
                          input logic [15:0] resp, input string tag, input bit poke);
        logic [31:0] v;
        m_tag = tag; m_err = 0;
        m_rd = (c == 3'd7); m_ta = ta; m_resp = resp;
        m_f0 = frame_bits(2'b00, p, d, ra);
        m_f1 = frame_bits(m_rd ? 2'b11 : 2'b01, p, d, dat);
        wr(4'h0, mk(c, p, d, dat), 1);
        repeat (60) @(negedge clk);
        rd(4'h0, v);
        chk("R3 busy mid-access", 32'(v[30]), 32'h1);
        chk("R8 read-valid cleared at launch", 32'(v[29]), 32'h0);
        if (poke) begin
            // R11: both registers written while busy
            wr(4'h0, mk(3'd5, 5'h00, 5'h00, 16'h0000), 0);
            wr(4'h8, 32'h0000_5555, 0);
        end
        wait (!m_on);
        @(negedge clk);
        total++;
        if (m_err != 0) bad++;
    endtask

    initial begin
        logic [31:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        rd(4'h0, v); chk("R1 mgmt after reset", v, 32'h0);
        rd(4'h8, v); chk("R1 addr after reset", v, 32'h0);
        chk("R1 mdc/oe idle", {30'h0, mdc, mdio_oe}, 32'h0);

        wr(4'h8, 32'hABCD_1234, 0);
        rd(4'h8, v); chk("R2 addr reg readback", v, 32'h0000_1234);

        run_op(3'd5, 5'h03, 5'h01, 16'hBEEF, 16'h1234, 1'b0, 16'h0,
               "R3 R4 R5 R7 write access", 0);
        rd(4'h0, v); chk("R5 R2 mgmt after write", v, mk(3'd5, 5'h03, 5'h01, 16'hBEEF));

        wr(4'h8, 32'h0000_FFFF, 0);
        run_op(3'd7, 5'h1F, 5'h1F, 16'h0000, 16'hFFFF, 1'b0, 16'hA5C3,
               "R4 R6 R7 read access", 1);
        rd(4'h0, v); chk("R8 R11 mgmt after good read", v,
                         mk(3'd7, 5'h1F, 5'h1F, 16'hA5C3) | 32'h2000_0000);
        rd(4'h8, v); chk("R11 addr reg kept", v, 32'h0000_FFFF);

        wr(4'h8, 32'h0000_0000, 0);
        run_op(3'd7, 5'h00, 5'h00, 16'h7E7E, 16'h0000, 1'b1, 16'h1234,
               "R6 R9 read bad turnaround", 0);
        rd(4'h0, v); chk("R9 mgmt after bad turnaround", v, mk(3'd7, 5'h00, 5'h00, 16'h7E7E));

        wr(4'h0, mk(3'd3, 5'h05, 5'h06, 16'h1111), 0);
        wr(4'h0, mk(3'd0, 5'h07, 5'h08, 16'h2222), 0);
        repeat (8) @(negedge clk);
        chk("R10 line quiet", {30'h0, mdc, mdio_oe}, 32'h0);
        rd(4'h0, v); chk("R10 mgmt unchanged", v, mk(3'd7, 5'h00, 5'h00, 16'h7E7E));

        wr(4'h8, 32'h0000_8001, 0);
        run_op(3'd5, 5'h10, 5'h0A, 16'h0001, 16'h8001, 1'b0, 16'h0,
               "R3 R4 R5 second write", 0);
        rd(4'h0, v); chk("R5 mgmt after second write", v, mk(3'd5, 5'h10, 5'h0A, 16'h0001));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule